// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block turns a 64-bit system physical address into a 32-bit core-local address. It does this through five base-and-mask window records. Two of them are pinned 64 MiB windows. Software loads their tags once through a plain configuration port, and after that they only ever produce hits. The other three are 16 MiB dynamic windows. When a lookup matches no record, one of these dynamic windows is refilled in round-robin order. No legality check of any kind is applied to the address.

A lookup arrives as a valid/ready request and leaves as a valid/ready response. On a miss the block first installs the new tag. It then issues two writes on a valid/ready window-programming port, which reprograms the hardware window behind the refilled slot. The response is released only after both writes have been accepted. Back-pressure rules:
- The block raises `req_ready` only while it is idle.
- It holds `rsp_*` stable while `rsp_ready` is low.
- It holds `win_*` stable while `win_ready` is low.
- While a response or a programming write is outstanding, the block accepts no new request.

Top module: `wt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `win_valid` are 0. All dynamic records are invalid and the allocation pointer is 0, so the first miss uses slot 0. Pinned records stay invalid until they are configured.
- R2: A record hits when (address AND mask) equals its stored tag. The response address is then the record's local base plus the address bits that the mask clears, truncated to 32 bits.
- R3: Records 3 and 4 are pinned. Their masks clear the low 26 bits and their local bases are 0x80000000 and 0x84000000. A pulse on `cfg_we` with `cfg_sel`=0 loads record 3, and with `cfg_sel`=1 loads record 4. The stored tag is `cfg_tag` with its low 26 bits cleared, and the record becomes valid. A miss never replaces a pinned record.
- R4: Records 0, 1 and 2 are dynamic. Their masks clear the low 24 bits and their local bases are 0x07000000, 0x09000000 and 0x0A000000.
- R5: When several records match, the lowest-numbered record is used.
- R6: On a miss, the victim is the allocation pointer, which then advances as (victim+1) mod 3. A fourth distinct 16 MiB region therefore evicts the oldest dynamic slot.
- R7: On a miss, the victim's tag becomes the address with its low 24 bits cleared. Two writes follow, in this order:
  - first, `win_addr` = L+4 with `win_data` = address[63:32];
  - then, `win_addr` = L with `win_data` = address[31:0] with its low 24 bits cleared.
  Here L = 0x1000 + 0x10 × slot. The response address is the slot base plus address[23:0].
- R8: No null or range check is made. Any address that misses, including 0, evicts a slot and programs a window normally.
- R9: A miss response appears only after both window writes have been accepted. `req_ready` stays 0 from the accepted request until the response has been accepted.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, every `rsp_*` output holds. While `win_valid` is 1 and `win_ready` is 0, `win_addr` and `win_data` hold.
- R11: `rsp_hit` is 1 for a hit and 0 for a miss. `rsp_slot` gives the record index, 0 to 4, that produced the address. A miss always reports a slot from 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load one pinned record this cycle |
| cfg_sel | input | 1 | Pinned record select: 0 = record 3, 1 = record 4 |
| cfg_tag | input | 64 | System address whose 64 MiB region the pinned record covers |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 64 | System physical address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Core-local translated address |
| rsp_hit | output | 1 | 1 = hit, 0 = miss with refill |
| rsp_slot | output | 3 | Record index used |
| win_valid | output | 1 | Window-register write valid |
| win_ready | input | 1 | Programming port takes the write |
| win_addr | output | 32 | Window register location plus 0 or 4 |
| win_data | output | 32 | Word written to the window register |

## Verification
The bound checker watches the handshakes on every cycle:
- stability of the response and the window writes under back-pressure;
- `req_ready` low while work is outstanding;
- an upper-word write always followed by a lower-word write;
- a miss response only directly after the lower-word write;
- pinned slots never reported as misses.

Only the bench scenarios can show the rest, by running a behavioural record model against the design:
- the translated addresses;
- which slot a refill picks, and eviction order over several regions;
- lowest-index priority when a dynamic slot overlaps a pinned window;
- the exact window-register words.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int ADDR_W = 64;
  localparam int LOC_W  = 32;
  localparam int NDYN   = 3;
  localparam int NPIN   = 2;
  localparam int NREC   = NDYN + NPIN;
  localparam int IDX_W  = $clog2(NREC);
  localparam int DYN_W  = $clog2(NDYN);
  localparam int PIN_W  = (NPIN > 1) ? $clog2(NPIN) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WHI, S_WLO, S_RSP} wt_state_t;
endpackage

// File: rtl/wt_match.sv
module wt_match #(
  parameter int N   = 5,
  parameter int AW  = 64,
  parameter int LW  = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          vld  [N],
  input  logic [AW-1:0] tag  [N],
  input  logic [AW-1:0] mask [N],
  input  logic [LW-1:0] base [N],
  output logic [N-1:0]  hit_vec,
  output logic [LW-1:0] loc  [N]
);
  for (genvar i = 0; i < N; i++) begin : g_rec
    logic [AW-1:0] off;
    assign off        = addr & ~mask[i];
    assign hit_vec[i] = vld[i] && ((addr & mask[i]) == tag[i]);
    assign loc[i]     = base[i] + off[LW-1:0];
  end
endmodule

// File: rtl/wt_pick.sv
module wt_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/wt_rr.sv
module wt_rr #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == W'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/wt_xlate.sv
module wt_xlate
  import wt_pkg::*;
#(
  parameter int          DYN_SHIFT     = 24,
  parameter int          PIN_SHIFT     = 26,
  parameter logic [31:0] DYN_BASE0     = 32'h0700_0000,
  parameter logic [31:0] DYN_BASE1     = 32'h0900_0000,
  parameter logic [31:0] DYN_BASE2     = 32'h0A00_0000,
  parameter logic [31:0] PIN_BASE0     = 32'h8000_0000,
  parameter logic [31:0] PIN_BASE1     = 32'h8400_0000,
  parameter logic [31:0] REGLOC_BASE   = 32'h0000_1000,
  parameter logic [31:0] REGLOC_STRIDE = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PIN_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_tag,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LOC_W-1:0]  rsp_addr,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_slot,
  output logic              win_valid,
  input  logic              win_ready,
  output logic [LOC_W-1:0]  win_addr,
  output logic [LOC_W-1:0]  win_data
);
  localparam logic [ADDR_W-1:0] DYN_MASK = ~((ADDR_W'(1) << DYN_SHIFT) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] PIN_MASK = ~((ADDR_W'(1) << PIN_SHIFT) - ADDR_W'(1));
  localparam logic [LOC_W-1:0]  BASES [NREC] = '{DYN_BASE0, DYN_BASE1, DYN_BASE2,
                                                 PIN_BASE0, PIN_BASE1};

  // record storage
  logic              vld_q  [NREC];
  logic [ADDR_W-1:0] tag_q  [NREC];
  logic [ADDR_W-1:0] mask_a [NREC];
  logic [LOC_W-1:0]  base_a [NREC];
  logic [LOC_W-1:0]  loc_a  [NREC];
  logic [NREC-1:0]   hit_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [DYN_W-1:0]  rr_ptr;

  wt_state_t         st_q;
  logic [LOC_W-1:0]  rsp_addr_q;
  logic              rsp_hit_q;
  logic [IDX_W-1:0]  slot_q;
  logic [LOC_W-1:0]  hi_q;
  logic [LOC_W-1:0]  lo_q;
  logic              accept;
  logic              miss_go;
  logic [LOC_W-1:0]  regloc;

  for (genvar i = 0; i < NREC; i++) begin : g_cfg
    assign mask_a[i] = (i < NDYN) ? DYN_MASK : PIN_MASK;
    assign base_a[i] = BASES[i];
  end

  wt_match #(.N(NREC), .AW(ADDR_W), .LW(LOC_W)) u_match (
    .addr    (req_addr),
    .vld     (vld_q),
    .tag     (tag_q),
    .mask    (mask_a),
    .base    (base_a),
    .hit_vec (hit_vec),
    .loc     (loc_a)
  );

  wt_pick #(.N(NREC), .IW(IDX_W)) u_pick (
    .vec (hit_vec),
    .any (any_hit),
    .idx (hit_idx)
  );

  assign accept  = req_valid && req_ready;
  assign miss_go = accept && !any_hit;

  wt_rr #(.N(NDYN), .W(DYN_W)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (miss_go),
    .ptr   (rr_ptr)
  );

  // record updates: pinned through the configuration port, dynamic by refill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREC; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREC; i++) begin
        if (i >= NDYN && cfg_we && (int'(cfg_sel) == i - NDYN)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= cfg_tag & PIN_MASK;
        end
        if (i < NDYN && miss_go && (int'(rr_ptr) == i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= req_addr & DYN_MASK;
        end
      end
    end
  end

  // request / programming / response sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      rsp_addr_q <= '0;
      rsp_hit_q  <= 1'b0;
      slot_q     <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          if (any_hit) begin
            rsp_addr_q <= loc_a[hit_idx];
            rsp_hit_q  <= 1'b1;
            slot_q     <= hit_idx;
            st_q       <= S_RSP;
          end else begin
            rsp_addr_q <= loc_a[IDX_W'(rr_ptr)];
            rsp_hit_q  <= 1'b0;
            slot_q     <= IDX_W'(rr_ptr);
            hi_q       <= req_addr[ADDR_W-1:ADDR_W-LOC_W];
            lo_q       <= req_addr[LOC_W-1:0] & DYN_MASK[LOC_W-1:0];
            st_q       <= S_WHI;
          end
        end
        S_WHI:   if (win_ready) st_q <= S_WLO;
        S_WLO:   if (win_ready) st_q <= S_RSP;
        default: if (rsp_ready) st_q <= S_IDLE;
      endcase
    end
  end

  assign regloc    = REGLOC_BASE + LOC_W'(slot_q) * REGLOC_STRIDE;
  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RSP);
  assign rsp_addr  = rsp_addr_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_slot  = slot_q;
  assign win_valid = (st_q == S_WHI) || (st_q == S_WLO);
  assign win_addr  = (st_q == S_WHI) ? regloc + 32'd4 : regloc;
  assign win_data  = (st_q == S_WHI) ? hi_q : lo_q;
endmodule

// File: rtl/wt_xlate_chk.sv
module wt_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_hit,
  input logic [2:0]  rsp_slot,
  input logic        win_valid,
  input logic        win_ready,
  input logic [31:0] win_addr,
  input logic [31:0] win_data
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit) && $stable(rsp_slot)); // R10
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !win_ready |=> win_valid && $stable(win_addr) && $stable(win_data)); // R10
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid || rsp_valid) |-> !req_ready); // R9
  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && win_ready && win_addr[2] |=> win_valid && !win_addr[2]); // R7
  AST_MISS_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_hit |-> $past(win_valid && win_ready && !win_addr[2])); // R9
  AST_PIN_ONLY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_slot >= 3'd3 |-> rsp_hit); // R3
  AST_MISS_DYN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_slot < 3'd3); // R11
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && win_valid)); // R9
endmodule

bind wt_xlate wt_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_hit   (rsp_hit),
  .rsp_slot  (rsp_slot),
  .win_valid (win_valid),
  .win_ready (win_ready),
  .win_addr  (win_addr),
  .win_data  (win_data)
);

// File: tb/wt_xlate_bench.sv
module wt_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [63:0] cfg_tag = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_slot;
  logic        win_valid;
  logic        win_ready = 1'b0;
  logic [31:0] win_addr;
  logic [31:0] win_data;

  always #10 clk = ~clk;

  wt_xlate u_wt_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_tag(cfg_tag),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_hit(rsp_hit), .rsp_slot(rsp_slot), .win_valid(win_valid),
    .win_ready(win_ready), .win_addr(win_addr), .win_data(win_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  // behavioural reference model of the record set
  logic [63:0] m_tag [5];
  bit          m_vld [5];
  int          m_ptr;

  function automatic logic [63:0] m_mask(int i);
    return (i < 3) ? ~64'h00FF_FFFF : ~64'h03FF_FFFF;
  endfunction

  function automatic logic [31:0] m_base(int i);
    case (i)
      0: return 32'h0700_0000;
      1: return 32'h0900_0000;
      2: return 32'h0A00_0000;
      3: return 32'h8000_0000;
      default: return 32'h8400_0000;
    endcase
  endfunction

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic pin(bit sel, logic [63:0] t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_tag = t;
    @(negedge clk);
    cfg_we = 1'b0;
    m_tag[3 + int'(sel)] = t & m_mask(3);
    m_vld[3 + int'(sel)] = 1'b1;
  endtask

  task automatic expect_win(logic [31:0] ea, logic [31:0] ed, int stall, string r);
    for (int k = 0; k <= stall; k++) begin
      chk(win_valid === 1'b1, r, 64'(win_valid), 64'd1);
      chk(win_addr === ea, r, 64'(win_addr), 64'(ea));
      chk(win_data === ed, r, 64'(win_data), 64'(ed));
      chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R9", 64'({req_ready, rsp_valid}), 64'd0);
      win_ready = (k == stall);
      @(negedge clk);
    end
    win_ready = 1'b0;
  endtask

  task automatic lookup(logic [63:0] a, int wstall, int rstall, string r);
    int idx = -1;
    bit hit;
    logic [31:0] ea;
    logic [31:0] loc;
    for (int i = 0; i < 5; i++)
      if (idx < 0 && m_vld[i] && ((a & m_mask(i)) == m_tag[i])) idx = i;
    hit = (idx >= 0);
    if (hit) begin
      ea = m_base(idx) + 32'(a & ~m_mask(idx));
    end else begin
      idx = m_ptr;
      m_tag[idx] = a & m_mask(idx);
      m_vld[idx] = 1'b1;
      m_ptr = (m_ptr + 1) % 3;
      ea = m_base(idx) + {8'h00, a[23:0]};
    end
    loc = 32'h1000 + 32'(idx) * 32'h10;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0;
    if (!hit) begin
      expect_win(loc + 32'd4, a[63:32], wstall, "R7");
      expect_win(loc, {a[31:24], 24'h0}, 0, "R7");
    end
    for (int k = 0; k <= rstall; k++) begin
      chk(rsp_valid === 1'b1, r, 64'(rsp_valid), 64'd1);
      chk(rsp_addr === ea, r, 64'(rsp_addr), 64'(ea));
      chk(rsp_hit === hit, "R11", 64'(rsp_hit), 64'(hit));
      chk(rsp_slot === 3'(idx), "R11", 64'(rsp_slot), 64'(idx));
      chk(req_ready === 1'b0 && win_valid === 1'b0, "R9", 64'({req_ready, win_valid}), 64'd0);
      rsp_ready = (k == rstall);
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0, "R10", 64'(rsp_valid), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m_tag[i] = '0; m_vld[i] = 1'b0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1", 64'(req_ready), 64'd1);
    chk(rsp_valid === 1'b0, "R1", 64'(rsp_valid), 64'd0);
    chk(win_valid === 1'b0, "R1", 64'(win_valid), 64'd0);
    // R1/R7: first miss lands in slot 0
    lookup(64'h0000_0012_3456_789A, 0, 0, "R1");
    // R2: hit at the top of the 16 MiB window
    lookup(64'h0000_0012_34FF_FFFF, 0, 0, "R2");
    // R10: programming back-pressure, R4 slot 1 base
    lookup(64'hDEAD_BEEF_0100_0000, 3, 0, "R4");
    // R10: response back-pressure, slot 2
    lookup(64'h0000_0020_0000_1234, 0, 2, "R10");
    // R8: null address misses, evicts oldest (slot 0)
    lookup(64'h0000_0000_0000_0000, 1, 1, "R8");
    // R6: first region returns, evicts slot 1
    lookup(64'h0000_0012_3456_789A, 0, 0, "R6");
    // R3: load both pinned windows
    pin(1'b0, 64'h0000_0020_0000_0000);
    pin(1'b1, 64'h0000_0040_0BAD_0000);
    // R5: dynamic slot 2 overlaps pinned record 3, lowest index wins
    lookup(64'h0000_0020_0000_1234, 0, 0, "R5");
    // R3: pinned hits at window edges
    lookup(64'h0000_0020_03FF_FFFF, 0, 0, "R3");
    lookup(64'h0000_0040_0BFF_FFFF, 0, 0, "R3");
    lookup(64'h0000_0040_0800_0000, 0, 0, "R3");
    // R6: a run of misses cycling the pointer; pinned records survive
    for (int i = 0; i < 5; i++)
      lookup(64'h0000_0100_0000_0000 + 64'(i) * 64'h0100_0000 + 64'h55, i % 2, 0, "R6");
    lookup(64'h0000_0020_0000_1234, 0, 0, "R3");
    lookup(64'h0000_0040_0BAD_BEEF, 0, 0, "R3");
    // R8: all-ones address refills without error
    lookup(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R8");
    finish_run();
  end
endmodule